// File: doc/BRIEF.md
# Multi-Context Folding Logic Element

This block is one logic element that time-shares a single 4-input lookup table and two flip-flops among several computations. A small local bank holds up to sixteen configuration words. Each word carries a truth table, a D-input source choice for each flip-flop and a capture enable for each flip-flop. While the element runs, it evaluates the current word on every clock cycle. After a programmable number of evaluations, called the folding level, it moves to the next word.

Configuration words are preloaded through a simple address/data/write-enable port while the run input is low. Two settings shape the schedule. `fold_lvl_m1` is the folding level minus one, so each word stays active for `fold_lvl_m1 + 1` cycles. `ctx_cnt_m1` is the number of words in use minus one; after the last word the schedule returns to word 0. When run is low, the schedule restarts from word 0 and step 0. A flip-flop whose enable is clear keeps its value, so results can pass from one folding cycle to a later one.

Top module: `fold_le`

## Requirements
- R1: Synchronous active-high reset clears both flip-flop outputs and returns the schedule to context 0, step 0.
- R2: `lut_out` is combinational and equals bit `lut_in` of the active context's truth table, which is held in `cfg_data[15:0]`.
- R3: When a flip-flop captures, `cfg_data[16]` (for `q0`) or `cfg_data[17]` (for `q1`) picks its D input: 0 selects `lut_out` and 1 selects `prim_in`.
- R4: A flip-flop captures on a rising edge only while run is high and its enable bit is set: `cfg_data[18]` for `q0`, `cfg_data[19]` for `q1`. Otherwise it holds its value.
- R5: While run is high, the active context advances by one after every `fold_lvl_m1 + 1` rising edges. After k edges the active context is (k / (fold_lvl_m1+1)) mod (ctx_cnt_m1+1).
- R6: After the context numbered `ctx_cnt_m1` finishes its steps, the next context is 0.
- R7: While run is low, the schedule returns to context 0, step 0 on the next edge, and both flip-flops hold.
- R8: A context write takes effect only while run is low; a write attempted while run is high leaves the stored context unchanged.
- R9: With `fold_lvl_m1 = 0`, the element switches context on every rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | High: evaluate and fold; low: idle and allow context writes |
| fold_lvl_m1 | input | 4 | Folding level minus one |
| ctx_cnt_m1 | input | 4 | Number of contexts in use minus one |
| lut_in | input | 4 | LUT select inputs |
| prim_in | input | 1 | Primary data input for the flip-flop muxes |
| cfg_we | input | 1 | Context write strobe |
| cfg_addr | input | 4 | Context write address |
| cfg_data | input | 20 | Context word: [15:0] truth table, [17:16] D selects, [19:18] enables |
| lut_out | output | 1 | LUT output for the active context |
| q0 | output | 1 | Flip-flop 0 output |
| q1 | output | 1 | Flip-flop 1 output |

## Verification
The embedded assertions check these rules on every cycle:
- The schedule pointer holds between wrap points, returns to zero at the end of the sequence and whenever run is low.
- A disabled flip-flop holds, and an enabled one selecting the LUT takes the prior LUT value.
- A stored context is untouched by writes made during a run.

Only the bench's scenarios can show the following:
- The full fold arithmetic across several folding levels and context counts.
- The primary-input capture path.
- The truth-table indexing.
- That reset takes priority over an active run.

// File: rtl/fold_le_pkg.sv
`timescale 1ns/1ps
package fold_le_pkg;

    localparam int LUT_K   = 4;
    localparam int TT_W    = 1 << LUT_K;
    localparam int N_REG   = 2;
    localparam int MAX_CTX = 16;
    localparam int STEP_W  = 4;

    typedef struct packed {
        logic [N_REG-1:0] we;
        logic [N_REG-1:0] sel;
        logic [TT_W-1:0]  tt;
    } ctx_t;

    localparam int CTX_W = $bits(ctx_t);

    function automatic logic lut_eval(input logic [TT_W-1:0] tt, input logic [LUT_K-1:0] idx);
        return tt[idx];
    endfunction

endpackage

// File: rtl/fold_ctx_store.sv
`timescale 1ns/1ps
module fold_ctx_store
    import fold_le_pkg::*;
#(
    parameter int DEPTH = MAX_CTX,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  ctx_t          wr_data,
    input  logic [AW-1:0] rd_addr,
    output ctx_t          rd_ctx
);

    ctx_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && !run)
            mem[wr_addr] <= wr_data;
    end

    assign rd_ctx = mem[rd_addr];

    // R8: writes during a run leave the addressed word untouched
    assert_write_locked_R8: assert property (@(posedge clk) disable iff (rst)
        (run && wr_en) |=> mem[$past(wr_addr)] == $past(mem[wr_addr]));

endmodule

// File: rtl/fold_sequencer.sv
`timescale 1ns/1ps
module fold_sequencer
    import fold_le_pkg::*;
#(
    parameter int DEPTH = MAX_CTX,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [STEP_W-1:0] lvl_m1,
    input  logic [AW-1:0]     cnt_m1,
    output logic [AW-1:0]     ptr
);

    logic [STEP_W-1:0] step;
    logic              wrap_step;
    logic              wrap_ctx;

    assign wrap_step = (step >= lvl_m1);
    assign wrap_ctx  = (ptr >= cnt_m1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            step <= '0;
            ptr  <= '0;
        end else if (wrap_step) begin
            step <= '0;
            ptr  <= wrap_ctx ? '0 : ptr + 1'b1;
        end else begin
            step <= step + 1'b1;
        end
    end

    // R5: pointer only moves when the step counter wraps
    assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (run && step < lvl_m1) |=> ptr == $past(ptr));

    // R6: end of plane cycle returns to context 0
    assert_ptr_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (run && step >= lvl_m1 && ptr >= cnt_m1) |=> ptr == '0);

    // R7: idle returns the schedule to the start
    assert_idle_clear_R7: assert property (@(posedge clk) disable iff (rst)
        !run |=> (ptr == '0 && step == '0));

endmodule

// File: rtl/fold_lut_regs.sv
`timescale 1ns/1ps
module fold_lut_regs
    import fold_le_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  ctx_t             ctx,
    input  logic [LUT_K-1:0] lut_in,
    input  logic             prim_in,
    output logic             lut_out,
    output logic [N_REG-1:0] q
);

    assign lut_out = lut_eval(ctx.tt, lut_in);

    for (genvar i = 0; i < N_REG; i++) begin : g_reg
        logic d;
        assign d = ctx.sel[i] ? prim_in : lut_out;

        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= 1'b0;
            else if (run && ctx.we[i])
                q[i] <= d;
        end

        // R4: a register without capture permission keeps its value
        assert_reg_hold_R4: assert property (@(posedge clk) disable iff (rst)
            !(run && ctx.we[i]) |=> q[i] == $past(q[i]));

        // R3: a capture from the LUT path takes the prior LUT value
        assert_lut_capture_R3: assert property (@(posedge clk) disable iff (rst)
            (run && ctx.we[i] && !ctx.sel[i]) |=> q[i] == $past(lut_out));
    end

endmodule

// File: rtl/fold_le.sv
`timescale 1ns/1ps
module fold_le
    import fold_le_pkg::*;
#(
    parameter int DEPTH = MAX_CTX,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [STEP_W-1:0] fold_lvl_m1,
    input  logic [AW-1:0]     ctx_cnt_m1,
    input  logic [LUT_K-1:0]  lut_in,
    input  logic              prim_in,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [CTX_W-1:0]  cfg_data,
    output logic              lut_out,
    output logic              q0,
    output logic              q1
);

    ctx_t             wr_word;
    ctx_t             cur_ctx;
    logic [AW-1:0]    ptr;
    logic [N_REG-1:0] q;

    assign wr_word = ctx_t'(cfg_data);

    fold_ctx_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (wr_word),
        .rd_addr (ptr),
        .rd_ctx  (cur_ctx)
    );

    fold_sequencer #(.DEPTH(DEPTH)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .lvl_m1 (fold_lvl_m1),
        .cnt_m1 (ctx_cnt_m1),
        .ptr    (ptr)
    );

    fold_lut_regs u_core (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .ctx     (cur_ctx),
        .lut_in  (lut_in),
        .prim_in (prim_in),
        .lut_out (lut_out),
        .q       (q)
    );

    assign q0 = q[0];
    assign q1 = q[1];

endmodule

// File: tb/fold_le_test.sv
`timescale 1ns/1ps
module fold_le_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic [3:0]  fold_lvl_m1 = '0;
    logic [3:0]  ctx_cnt_m1 = '0;
    logic [3:0]  lut_in = '0;
    logic        prim_in = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [19:0] cfg_data = '0;
    logic        lut_out, q0, q1;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    fold_le uut (
        .clk(clk), .rst(rst), .run(run), .fold_lvl_m1(fold_lvl_m1),
        .ctx_cnt_m1(ctx_cnt_m1), .lut_in(lut_in), .prim_in(prim_in),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .lut_out(lut_out), .q0(q0), .q1(q1)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // identify the active context: context c has only truth-table bit c set
    task automatic scan(output int c);
        c = -1;
        for (int i = 15; i >= 0; i--) begin
            lut_in = 4'(i);
            #0.2;
            if (lut_out) c = i;
        end
        lut_in = '0;
    endtask

    task automatic write_ctx(input int a, input logic [1:0] we, input logic [1:0] sel,
                             input logic [15:0] tt);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_data = {we, sel, tt};
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_ids(input int n);
        for (int c = 0; c < n; c++) write_ctx(c, 2'b00, 2'b00, 16'h1 << c);
    endtask

    task automatic test_reset;
        int c;
        load_ids(16);
        ctx_cnt_m1 = 4'd15; fold_lvl_m1 = 4'd0;
        @(negedge clk); run = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 q0 after reset", q0, 0);
        chk("R1 q1 after reset", q1, 0);
        scan(c);
        chk("R1 context after reset", c, 0);
        rst = 1'b0; run = 1'b0;
        @(negedge clk);
    endtask

    task automatic test_lut;
        int c;
        for (int v = 0; v < 16; v += 5) begin
            lut_in = 4'(v);
            #0.5;
            chk("R2 lut_out on context 0", lut_out, (v == 0) ? 1 : 0);
        end
        scan(c);
        chk("R2 only truth-table bit 0 set", c, 0);
    endtask

    task automatic test_fold(input int p, input int n, input int steps, input string req);
        int c;
        load_ids(n);
        fold_lvl_m1 = 4'(p - 1); ctx_cnt_m1 = 4'(n - 1);
        @(negedge clk); run = 1'b1;
        scan(c);
        chk({req, " start context"}, c, 0);
        for (int k = 1; k <= steps; k++) begin
            @(negedge clk);
            scan(c);
            chk(req, c, (k / p) % n);
        end
        run = 1'b0;
        @(negedge clk);
        scan(c);
        chk("R7 idle returns to context 0", c, 0);
    endtask

    task automatic test_regs;
        write_ctx(0, 2'b01, 2'b00, 16'h0001);
        write_ctx(1, 2'b10, 2'b10, 16'h0002);
        fold_lvl_m1 = 4'd0; ctx_cnt_m1 = 4'd1;
        @(negedge clk);
        lut_in = 4'd0; prim_in = 1'b1; run = 1'b1;
        @(negedge clk);
        chk("R3 q0 captured lut_out", q0, 1);
        chk("R4 q1 held without enable", q1, 0);
        @(negedge clk);
        chk("R3 q1 captured prim_in", q1, 1);
        chk("R4 q0 held without enable", q0, 1);
        lut_in = 4'd5; prim_in = 1'b0;
        @(negedge clk);
        chk("R3 q0 captured lut_out low", q0, 0);
        chk("R4 q1 held", q1, 1);
        run = 1'b0; lut_in = 4'd0; prim_in = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 q0 holds while idle", q0, 0);
        chk("R7 q1 holds while idle", q1, 1);
    endtask

    task automatic test_write_lock;
        int c;
        load_ids(2);
        fold_lvl_m1 = 4'd0; ctx_cnt_m1 = 4'd1;
        @(negedge clk); run = 1'b1;
        cfg_we = 1'b1; cfg_addr = 4'd0; cfg_data = {4'b0000, 16'hFFFF};
        @(negedge clk); cfg_addr = 4'd1;
        @(negedge clk); cfg_we = 1'b0; run = 1'b0;
        @(negedge clk);
        scan(c);
        chk("R8 context 0 unchanged", c, 0);
        lut_in = 4'd7; #0.5;
        chk("R8 context 0 bit 7 still clear", lut_out, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_lut();
        test_fold(3, 4, 14, "R5 fold p=3 n=4");
        test_fold(2, 3, 12, "R6 wrap p=2 n=3");
        test_fold(1, 16, 18, "R9 level-1 n=16");
        test_regs();
        test_write_lock();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            nchk++; nerr++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

endmodule